// File: doc/BRIEF.md
# Split-Register Real-Time Counter

The block is a memory-mapped real-time counter. A 47-bit count advances by one on every strobe of a 32.768 kHz tick-enable input. Software sees the count through two 32-bit registers: a high register holding the upper 15 bits and a low register holding the lower 32 bits. Either half can be rewritten on its own while the other half keeps its value.

A third register, the low-power control register, stores whatever is written and returns it on read. A control write that has both bit 6 and bit 5 set also raises a one-cycle power-off request. The bus is a plain 32-bit register interface with address, write enable, write data and combinational read data. Writes take effect on the clock edge where the write enable is sampled.

Top module: `rtc_split_counter`

## Requirements
- R1: After reset the count is zero, the control register reads zero and the power-off request is low.
- R2: With the tick strobe high and no count write, the 47-bit count rises by exactly one per clock, carries from bit 31 into bit 32 and wraps from all ones to zero. With the strobe low and no write, the count holds.
- R3: A read at offset 0x50 returns count bits 46:32 in data bits 14:0. Data bits 31:15 read as zero.
- R4: A read at offset 0x54 returns count bits 31:0.
- R5: A write to offset 0x50 loads write-data bits 14:0 into count bits 46:32 and ignores write-data bits 31:15. Count bits 31:0 keep their value.
- R6: A write to offset 0x54 loads all 32 write-data bits into count bits 31:0. Count bits 46:32 keep their value.
- R7: When a count write and a tick strobe fall in the same cycle, the tick is dropped. The written half takes the data and the other half keeps its value, with no increment.
- R8: A write to offset 0x38 stores all 32 data bits, and a read of 0x38 returns them.
- R9: The power-off output pulses high for one cycle in the cycle after a write to 0x38 with data bits 6 and 5 both 1. A control write with only one of those bits set, or neither, gives no pulse.
- R10: A read of any offset other than 0x38, 0x50 and 0x54 returns zero. A write to such an offset changes neither the count nor the control register, and raises no power-off request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance strobe at the 32.768 kHz rate |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwr_off_o | output | 1 | Power-off request pulse |

## Verification
The assertions check the following on every clock:
- the count step under a lone tick, and that the count holds when idle;
- half-preserving loads of the high and low registers;
- control-register storage;
- that every power-off pulse traces back to a qualifying control write;
- that reads at unmapped offsets return zero.

Some behaviour only the bench scenarios show:
- carries across the 32-bit boundary and the 47-bit wrap;
- a tick dropped when it coincides with a write;
- the pulse being exactly one cycle long;
- full address sweeps showing that unmapped writes leave all state untouched.

// File: rtl/rtc_split_pkg.sv
package rtc_split_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;

  localparam int unsigned DEF_OFF_CTL = 32'h38;
  localparam int unsigned DEF_OFF_HI  = 32'h50;
  localparam int unsigned DEF_OFF_LO  = 32'h54;
endpackage

// File: rtl/rtc_split_dec.sv
module rtc_split_dec
  import rtc_split_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_HI  = DEF_OFF_HI,
  parameter int unsigned OFF_LO  = DEF_OFF_LO,
  parameter int unsigned OFF_CTL = DEF_OFF_CTL
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFF_HI))       sel_o = SEL_HI;
    else if (addr_i == ADDR_W'(OFF_LO))  sel_o = SEL_LO;
    else if (addr_i == ADDR_W'(OFF_CTL)) sel_o = SEL_CTL;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/rtc_split_cnt.sv
module rtc_split_cnt #(
  parameter int unsigned CNT_W  = 47,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // write wins over tick: one consistent snapshot per cycle
  always_comb begin
    if (wr_hi_i)      cnt_d = {wdata_i[HI_W-1:0], cnt_q[DATA_W-1:0]};
    else if (wr_lo_i) cnt_d = {cnt_q[CNT_W-1:DATA_W], wdata_i};
    else if (tick_i)  cnt_d = cnt_q + CNT_W'(1);
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_tick_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_hi_i && !wr_lo_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_hi_i && !wr_lo_i) |=> $stable(cnt_o));
  p_hi_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cnt_o[DATA_W-1:0] == $past(cnt_o[DATA_W-1:0])) &&
                (cnt_o[CNT_W-1:DATA_W] == $past(wdata_i[HI_W-1:0])));
  p_lo_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (cnt_o[CNT_W-1:DATA_W] == $past(cnt_o[CNT_W-1:DATA_W])) &&
                              (cnt_o[DATA_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/rtc_split_ctl.sv
module rtc_split_ctl #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFF_B_A = 6,
  parameter int unsigned OFF_B_B = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic              pwr_off_o
);
  logic [DATA_W-1:0] ctl_q;
  logic              pwr_q;
  logic              off_req;

  assign off_req = wr_i && wdata_i[OFF_B_A] && wdata_i[OFF_B_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      pwr_q <= 1'b0;
    end else begin
      if (wr_i) ctl_q <= wdata_i;
      pwr_q <= off_req;
    end
  end

  assign ctl_o     = ctl_q;
  assign pwr_off_o = pwr_q;

  p_ctl_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctl_o == $past(wdata_i));
  p_ctl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctl_o));
endmodule

// File: rtl/rtc_split_counter.sv
module rtc_split_counter
  import rtc_split_pkg::*;
#(
  parameter int unsigned CNT_W   = 47,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_HI  = DEF_OFF_HI,
  parameter int unsigned OFF_LO  = DEF_OFF_LO,
  parameter int unsigned OFF_CTL = DEF_OFF_CTL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwr_off_o
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - HI_W;

  reg_sel_e          sel;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctl;

  rtc_split_dec #(
    .ADDR_W(ADDR_W), .OFF_HI(OFF_HI), .OFF_LO(OFF_LO), .OFF_CTL(OFF_CTL)
  ) i_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  rtc_split_cnt #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_hi_i(wr_en_i && (sel == SEL_HI)),
    .wr_lo_i(wr_en_i && (sel == SEL_LO)),
    .wdata_i(wdata_i),
    .cnt_o  (cnt)
  );

  rtc_split_ctl #(.DATA_W(DATA_W)) i_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && (sel == SEL_CTL)),
    .wdata_i  (wdata_i),
    .ctl_o    (ctl),
    .pwr_off_o(pwr_off_o)
  );

  always_comb begin
    unique case (sel)
      SEL_HI:  rdata_o = {{PAD_W{1'b0}}, cnt[CNT_W-1:DATA_W]};
      SEL_LO:  rdata_o = cnt[DATA_W-1:0];
      SEL_CTL: rdata_o = ctl;
      default: rdata_o = '0;
    endcase
  end

  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(OFF_HI) && addr_i != ADDR_W'(OFF_LO) && addr_i != ADDR_W'(OFF_CTL))
      |-> rdata_o == '0);
  p_hi_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_HI)) |-> rdata_o[DATA_W-1:HI_W] == '0);
  p_pwr_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> $past(wr_en_i) && ($past(addr_i) == ADDR_W'(OFF_CTL)) &&
                  $past(wdata_i[6]) && $past(wdata_i[5]));
endmodule

// File: tb/test_rtc_split_counter.sv
module test_rtc_split_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwr_off_o;

  int checks = 0;
  int errors = 0;
  logic [46:0] exp_cnt = '0;
  logic [31:0] exp_ctl = '0;
  logic        pulse_seen;

  rtc_split_counter i_rtc_split_counter (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    addr_i = a;
    #2;
    chk(req, rdata_o, exp);
  endtask

  task automatic chk_count(input string req);
    rd(8'h50, req, {17'd0, exp_cnt[46:32]});
    rd(8'h54, req, exp_cnt[31:0]);
  endtask

  // drive at negedge, apply at posedge, return at next negedge with pulse sampled
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; tick_i = tk;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
    pulse_seen = pwr_off_o;
    if (a == 8'h50)      exp_cnt = {d[14:0], exp_cnt[31:0]};
    else if (a == 8'h54) exp_cnt = {exp_cnt[46:32], d};
    else if (a == 8'h38) exp_ctl = d;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
    exp_cnt = exp_cnt + 47'(n);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk_count("R1");
    rd(8'h38, "R1", 32'h0);
    chk("R1", {31'd0, pwr_off_o}, 32'h0);
    rst_ni = 1'b1;
    idle(2);
    chk_count("R1");

    // R2 counting, holding, carry and wrap
    ticks(37);
    chk_count("R2");
    idle(5);
    chk_count("R2");
    for (int k = 1; k <= 4; k++) begin
      wr(8'h54, 32'hFFFF_FFFF - 32'(k) + 32'd1, 1'b0);
      ticks(k + 1);
      chk_count("R2");
    end
    wr(8'h50, 32'h0000_7FFF, 1'b0);
    wr(8'h54, 32'hFFFF_FFFE, 1'b0);
    ticks(3);
    chk_count("R2");
    chk("R2", {15'd0, exp_cnt[46:32], 2'd0}, 32'h0);

    // R3/R5 high writes: upper data ignored, low preserved
    wr(8'h54, 32'hA5A5_1234, 1'b0);
    for (int k = 0; k < 16; k++) begin
      wr(8'h50, 32'hFFFF_0000 | (32'h1 << k), 1'b0);
      rd(8'h50, "R3", {17'd0, 15'((32'h1 << k) & 32'h7FFF)});
      rd(8'h54, "R5", 32'hA5A5_1234);
    end
    wr(8'h50, 32'hFFFF_FFFF, 1'b0);
    rd(8'h50, "R3", 32'h0000_7FFF);

    // R4/R6 low writes: high preserved
    wr(8'h50, 32'h0000_2C3D, 1'b0);
    for (int k = 0; k < 32; k++) begin
      wr(8'h54, 32'h1 << k, 1'b0);
      rd(8'h54, "R4", 32'h1 << k);
      rd(8'h50, "R6", 32'h0000_2C3D);
    end

    // R7 write and tick together: no increment
    wr(8'h54, 32'h0000_1000, 1'b1);
    chk_count("R7");
    wr(8'h50, 32'h0000_0123, 1'b1);
    chk_count("R7");
    ticks(1);
    chk_count("R7");

    // R8 control storage
    for (int k = 0; k < 8; k++) begin
      wr(8'h38, 32'h9E37_79B9 * 32'(k + 1) & ~32'h60, 1'b0);
      rd(8'h38, "R8", exp_ctl);
      chk("R9", {31'd0, pulse_seen}, 32'h0);
    end

    // R9 power-off sweep over bits 6:5 with varied background data
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 3; p++) begin
        logic [31:0] d;
        d = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FF9F : 32'h1357_8A0F & ~32'h60;
        d = d | (32'(b) << 5);
        wr(8'h38, d, 1'b0);
        chk("R9", {31'd0, pulse_seen}, {31'd0, b == 3});
        idle(1);
        chk("R9", {31'd0, pwr_off_o}, 32'h0);
        rd(8'h38, "R8", d);
      end
    end

    // R10 unmapped reads over the whole address space
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h38 && a != 8'h50 && a != 8'h54) rd(8'(a), "R10", 32'h0);
    end

    // R10 unmapped writes leave all state untouched
    wr(8'h38, 32'h0000_0011, 1'b0);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h38 && a != 8'h50 && a != 8'h54) begin
        wr(8'(a), 32'hFFFF_FFFF, 1'b0);
        if (pulse_seen) chk("R10", 32'h1, 32'h0);
      end
    end
    checks++;
    chk_count("R10");
    rd(8'h38, "R10", 32'h0000_0011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule